// File: doc/BRIEF.md
# Nonvolatile SRAM Mode Controller

This controller sits in front of an SRAM array that keeps a nonvolatile shadow copy. Every clock it decodes four active-low control inputs (chip select, output enable, write enable, nonvolatile select) into one access mode. In normal operation it turns read and write modes into strobes for the array and drives the data-bus output enable. When the inputs move into a save or restore mode, it starts a bulk transfer: a save copies the SRAM into the shadow, and a restore copies the shadow back into the SRAM. While a transfer runs, the bus is kept quiet.

A transfer is started by holding `store_go` or `recall_go` high. The transfer engine raises `xfer_done` when it has finished. A parameterized cycle limit ends the transfer if `xfer_done` never arrives. A transfer starts only on entry into its decoded mode from a mode that is neither save nor restore, so inputs parked in a request mode cannot start a second transfer. A digital supply-good flag controls save transfers. A save cannot start while the flag is low, and a save that is running is aborted when the flag drops. The first time the flag is seen high after reset, a restore starts automatically and runs for a longer power-up period. The SRAM cannot be accessed before that restore ends.

Top module: `nvm_mode_ctrl`

## Requirements
- R1: `rd_stb` and `dq_oe` are high exactly when access is allowed and ce_n=0, oe_n=0, we_n=1, nv_n=1.
- R2: `wr_stb` is high exactly when access is allowed and ce_n=0, we_n=0, nv_n=1. With ce_n=1 (standby), no strobe is raised and `dq_oe` stays low.
- R3: A save starts on the clock edge where the inputs first decode as ce_n=0, we_n=0, oe_n=1, nv_n=0, coming from a mode that is neither save nor restore, with `pwr_ok` high. `store_go` is high from the next cycle.
- R4: A restore starts on the edge where the inputs first decode as ce_n=0, oe_n=0, we_n=1, nv_n=0, coming from a mode that is neither save nor restore. `recall_go` is high from the next cycle.
- R5: If the request inputs are still held when a transfer ends, no further transfer starts.
- R6: While `store_go` or `recall_go` is high, the control inputs are ignored. `rd_stb`, `wr_stb` and `dq_oe` stay low.
- R7: `store_go` or `recall_go` falls one cycle after `xfer_done` is sampled high. If `xfer_done` does not come, it falls after STORE_CYC cycles (save), RECALL_CYC cycles (restore) or PWRUP_CYC cycles (power-up restore).
- R8: A save request is refused while `pwr_ok` is low. A running save ends, with `store_go` low, in the cycle after `pwr_ok` is sampled low.
- R9: After reset, `busy` is high and all access is blocked until `pwr_ok` is first sampled high. A restore then runs for PWRUP_CYC cycles.
- R10: In the cycle right after a transfer ends, a read or write mode present on the inputs takes effect.
- R11: `busy` is high whenever a transfer is running and for one cycle after it ends.
- R12: While we_n=0, `dq_oe` is low, even when oe_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile select, active low |
| pwr_ok | input | 1 | Supply-good flag |
| xfer_done | input | 1 | Transfer engine finished |
| rd_stb | output | 1 | Array read strobe |
| wr_stb | output | 1 | Array write strobe |
| store_go | output | 1 | Save transfer active |
| recall_go | output | 1 | Restore transfer active |
| dq_oe | output | 1 | Data-bus output enable |
| busy | output | 1 | Transfer running, draining or not yet powered up |

## Verification
The assertions assume that the control inputs and `pwr_ok` are already synchronous to `clk` and hold one value per cycle. They also assume that `xfer_done` is a pulse that the transfer engine gives only while a go level is high. The stimulus changes inputs just after the falling edge and raises `xfer_done` for a single cycle, and only during a running restore. `pwr_ok` goes low only in the scenarios that test refusal and abort.

// File: rtl/nvm_mode_pkg.sv
package nvm_mode_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_NOP,
    M_READ,
    M_WRITE,
    M_STORE,
    M_RECALL
  } ctl_mode_e;

  typedef enum logic [1:0] {
    K_STORE,
    K_RECALL,
    K_POWERUP
  } xfer_kind_e;

  typedef enum logic [1:0] {
    S_UNPOWERED,
    S_READY,
    S_XFER,
    S_DRAIN
  } seq_state_e;

  function automatic logic is_xfer_mode(ctl_mode_e m);
    return (m == M_STORE) || (m == M_RECALL);
  endfunction

endpackage

// File: rtl/nvm_mode_decode.sv
module nvm_mode_decode
  import nvm_mode_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      nv_n,
  output ctl_mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = M_STANDBY;
    end else if (!nv_n) begin
      if (!we_n && oe_n)      mode = M_STORE;
      else if (we_n && !oe_n) mode = M_RECALL;
      else                    mode = M_NOP;
    end else if (!we_n) begin
      mode = M_WRITE;
    end else if (!oe_n) begin
      mode = M_READ;
    end else begin
      mode = M_NOP;
    end
  end

endmodule

// File: rtl/nvm_entry_detect.sv
module nvm_entry_detect
  import nvm_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctl_mode_e mode,
  output logic      store_hit,
  output logic      recall_hit
);

  ctl_mode_e prev_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_mode <= M_STANDBY;
    else        prev_mode <= mode;
  end

  // a request counts only when entered from a non-request mode
  assign store_hit  = (mode == M_STORE)  && !is_xfer_mode(prev_mode);
  assign recall_hit = (mode == M_RECALL) && !is_xfer_mode(prev_mode);

endmodule

// File: rtl/nvm_xfer_seq.sv
module nvm_xfer_seq
  import nvm_mode_pkg::*;
#(
  parameter int STORE_CYC  = 1250000,
  parameter int RECALL_CYC = 2500,
  parameter int PWRUP_CYC  = 81250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic store_hit,
  input  logic recall_hit,
  input  logic pwr_ok,
  input  logic xfer_done,
  output logic store_go,
  output logic recall_go,
  output logic busy,
  output logic access_ok
);

  localparam int MAX_A = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAX_C = (MAX_A > PWRUP_CYC) ? MAX_A : PWRUP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] LIM_STORE  = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] LIM_RECALL = CW'(RECALL_CYC - 1);
  localparam logic [CW-1:0] LIM_PWRUP  = CW'(PWRUP_CYC - 1);

  seq_state_e      state;
  xfer_kind_e      kind;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lim;
  logic            finish;

  always_comb begin
    case (kind)
      K_STORE:  lim = LIM_STORE;
      K_RECALL: lim = LIM_RECALL;
      default:  lim = LIM_PWRUP;
    endcase
  end

  assign finish = xfer_done || (cnt == lim) || ((kind == K_STORE) && !pwr_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_UNPOWERED;
      kind  <= K_POWERUP;
      cnt   <= '0;
    end else begin
      case (state)
        S_UNPOWERED: begin
          if (pwr_ok) begin
            state <= S_XFER;
            kind  <= K_POWERUP;
            cnt   <= '0;
          end
        end
        S_READY, S_DRAIN: begin
          if (store_hit && pwr_ok) begin
            state <= S_XFER;
            kind  <= K_STORE;
            cnt   <= '0;
          end else if (recall_hit) begin
            state <= S_XFER;
            kind  <= K_RECALL;
            cnt   <= '0;
          end else begin
            state <= S_READY;
          end
        end
        S_XFER: begin
          if (finish) state <= S_DRAIN;
          else        cnt   <= cnt + 1'b1;
        end
        default: state <= S_UNPOWERED;
      endcase
    end
  end

  assign store_go  = (state == S_XFER) && (kind == K_STORE);
  assign recall_go = (state == S_XFER) && (kind != K_STORE);
  assign busy      = (state != S_READY);
  assign access_ok = (state == S_READY) || (state == S_DRAIN);

endmodule

// File: rtl/nvm_mode_ctrl.sv
module nvm_mode_ctrl
  import nvm_mode_pkg::*;
#(
  parameter int STORE_CYC  = 1250000,
  parameter int RECALL_CYC = 2500,
  parameter int PWRUP_CYC  = 81250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic nv_n,
  input  logic pwr_ok,
  input  logic xfer_done,
  output logic rd_stb,
  output logic wr_stb,
  output logic store_go,
  output logic recall_go,
  output logic dq_oe,
  output logic busy
);

  ctl_mode_e mode;
  logic      store_hit;
  logic      recall_hit;
  logic      access_ok;

  nvm_mode_decode u_decode (
    .ce_n (ce_n),
    .oe_n (oe_n),
    .we_n (we_n),
    .nv_n (nv_n),
    .mode (mode)
  );

  nvm_entry_detect u_entry (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .store_hit  (store_hit),
    .recall_hit (recall_hit)
  );

  nvm_xfer_seq #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC),
    .PWRUP_CYC  (PWRUP_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_hit  (store_hit),
    .recall_hit (recall_hit),
    .pwr_ok     (pwr_ok),
    .xfer_done  (xfer_done),
    .store_go   (store_go),
    .recall_go  (recall_go),
    .busy       (busy),
    .access_ok  (access_ok)
  );

  assign rd_stb = access_ok && (mode == M_READ);
  assign wr_stb = access_ok && (mode == M_WRITE);
  assign dq_oe  = rd_stb;

endmodule

// File: rtl/nvm_mode_ctrl_chk.sv
module nvm_mode_ctrl_chk #(
  parameter int STORE_CYC  = 1250000,
  parameter int RECALL_CYC = 2500,
  parameter int PWRUP_CYC  = 81250
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic nv_n,
  input logic pwr_ok,
  input logic rd_stb,
  input logic wr_stb,
  input logic store_go,
  input logic recall_go,
  input logic dq_oe,
  input logic busy
);

  localparam int RLIM = (RECALL_CYC > PWRUP_CYC) ? RECALL_CYC : PWRUP_CYC;

  int store_run;
  int recall_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_run  <= 0;
      recall_run <= 0;
    end else begin
      store_run  <= store_go  ? store_run + 1  : 0;
      recall_run <= recall_go ? recall_run + 1 : 0;
    end
  end

  assert_read_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> (!ce_n && !oe_n && we_n && nv_n));

  assert_write_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (!ce_n && !we_n && nv_n));

  assert_store_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_go) |-> $past(!ce_n && !we_n && oe_n && !nv_n));

  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_go) |-> !$past(!ce_n && !we_n && oe_n && !nv_n, 2));

  assert_quiet_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go || recall_go) |-> (!rd_stb && !wr_stb && !dq_oe));

  assert_one_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_go, recall_go}));

  assert_store_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_run <= STORE_CYC);

  assert_recall_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recall_run <= RLIM);

  assert_store_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_go) |-> $past(pwr_ok));

  assert_store_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go && !pwr_ok) |=> !store_go);

  assert_busy_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_go || recall_go) |-> busy);

  assert_busy_tail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(store_go || recall_go) |-> busy);

  assert_write_hiz_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_oe);

endmodule

bind nvm_mode_ctrl nvm_mode_ctrl_chk #(
  .STORE_CYC  (STORE_CYC),
  .RECALL_CYC (RECALL_CYC),
  .PWRUP_CYC  (PWRUP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .nv_n      (nv_n),
  .pwr_ok    (pwr_ok),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .store_go  (store_go),
  .recall_go (recall_go),
  .dq_oe     (dq_oe),
  .busy      (busy)
);

// File: tb/nvm_mode_ctrl_bench.sv
module nvm_mode_ctrl_bench;

  localparam int SC = 30;
  localparam int RC = 12;
  localparam int PC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
  logic pwr_ok = 1'b0, xfer_done = 1'b0;
  logic rd_stb, wr_stb, store_go, recall_go, dq_oe, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  nvm_mode_ctrl #(
    .STORE_CYC  (SC),
    .RECALL_CYC (RC),
    .PWRUP_CYC  (PC)
  ) u_nvm_mode_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .nv_n      (nv_n),
    .pwr_ok    (pwr_ok),
    .xfer_done (xfer_done),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .store_go  (store_go),
    .recall_go (recall_go),
    .dq_oe     (dq_oe),
    .busy      (busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic set_in(input bit ce, input bit oe, input bit we, input bit nv);
    ce_n = ce; oe_n = oe; we_n = we; nv_n = nv;
    #1;
  endtask

  task automatic count_go(input bit sel_store, output int n);
    n = 0;
    while ((sel_store ? store_go : recall_go) && n < 100000) begin
      n++;
      step();
    end
  endtask

  task automatic t_reset();
    step();
    rst_n = 1'b1;
    set_in(0, 0, 1, 1);
    step();
    check("R9", "busy before power", busy, 1);
    check("R9", "read blocked before power", rd_stb, 0);
    check("R9", "no restore before power", recall_go, 0);
  endtask

  task automatic t_powerup();
    int n;
    pwr_ok = 1'b1;
    step();
    check("R9", "power-up restore started", recall_go, 1);
    count_go(1'b0, n);
    check("R9", "power-up restore length", n, PC);
    check("R11", "busy in drain after power-up", busy, 1);
    check("R10", "read active right after restore", dq_oe, 1);
    step();
    check("R11", "busy cleared", busy, 0);
  endtask

  task automatic t_rw();
    set_in(0, 0, 1, 1);
    check("R1", "read strobe", rd_stb, 1);
    check("R1", "read drives bus", dq_oe, 1);
    set_in(0, 1, 0, 1);
    check("R2", "write strobe", wr_stb, 1);
    check("R2", "write no read", rd_stb, 0);
    set_in(0, 0, 0, 1);
    check("R12", "bus off while writing with oe low", dq_oe, 0);
    check("R12", "write still strobes", wr_stb, 1);
    set_in(1, 0, 1, 1);
    check("R2", "standby no write", wr_stb, 0);
    check("R2", "standby bus off", dq_oe, 0);
    step();
  endtask

  task automatic t_store();
    int n;
    set_in(0, 0, 1, 1);
    step();
    set_in(0, 1, 0, 0);
    step();
    check("R3", "save started on entry", store_go, 1);
    set_in(0, 0, 1, 1);
    check("R6", "read ignored during save", rd_stb, 0);
    check("R6", "bus off during save", dq_oe, 0);
    set_in(0, 1, 0, 0);
    count_go(1'b1, n);
    check("R7", "save length by limit", n, SC);
    check("R11", "busy in drain after save", busy, 1);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R5", "no retrigger while held", store_go, 0);
    end
    set_in(1, 1, 1, 1);
    step();
  endtask

  task automatic t_recall_done();
    set_in(1, 1, 1, 1);
    step();
    set_in(0, 0, 1, 0);
    step();
    check("R4", "restore started on entry", recall_go, 1);
    step();
    step();
    set_in(0, 0, 1, 1);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    check("R7", "restore ends on done", recall_go, 0);
    check("R11", "busy one cycle after done", busy, 1);
    check("R10", "read takes effect at once", rd_stb, 1);
    step();
    check("R11", "busy clear after drain", busy, 0);
  endtask

  task automatic t_inhibit();
    set_in(1, 1, 1, 1);
    pwr_ok = 1'b0;
    step();
    set_in(0, 1, 0, 0);
    step();
    step();
    check("R8", "save refused without supply", store_go, 0);
    check("R8", "no busy when refused", busy, 0);
    set_in(1, 1, 1, 1);
    pwr_ok = 1'b1;
    step();
  endtask

  task automatic t_abort();
    set_in(0, 1, 0, 0);
    step();
    check("R3", "save started again", store_go, 1);
    step();
    step();
    pwr_ok = 1'b0;
    step();
    check("R8", "save aborted on supply loss", store_go, 0);
    check("R11", "busy in drain after abort", busy, 1);
    step();
    check("R8", "idle after abort", busy, 0);
    pwr_ok = 1'b1;
    set_in(1, 1, 1, 1);
    step();
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_rw();
    t_store();
    t_recall_done();
    t_inhibit();
    t_abort();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule